// File: doc/BRIEF.md
# PCI Host Bridge Register Interface

This block is the memory-mapped control face of a host bridge between a local processor bus and a PCI segment. A simple 32-bit register bus (byte offset, read and write strobes, write data, read data, ready) reaches a 64-word local configuration header, a configuration-address register, a memory-base register and an I/O-window base register. A data port at a fixed offset turns each local access into one 4-byte configuration cycle on a downstream request/response pair. The cycle's address comes from the configuration-address register.

The block sees only the low offset bits of the access. A separate select input says that the local address fell into one of the aliased decode windows, so the same registers answer at every alias. The current I/O window base is driven out, with a one-cycle pulse each time that window moves. The window is 256 KiB long and starts at the base.

Top module: `pcib_regif`

## Requirements
- R1: Offsets 0x000 to 0x0FC (aligned words) address the local configuration space. A word written there reads back unchanged. Configuration byte n of a word sits in data bits [8n+7:8n], which is little-endian order.
- R2: After reset, configuration word 0 is {DEVICE_ID, VENDOR_ID}, configuration word 1 is 0x02900080 and every other configuration word is zero. The configuration-address register and the memory-base register are zero, and the I/O base is 0xFE240000. Ready, remap and request are all low.
- R3: Offset 0x1C0 is the configuration-address register. All 32 bits can be written and read back.
- R4: Offset 0x1C4 is the memory-base register. A write stores only bits 31:24 and bit 0, and every other bit reads back as zero.
- R5: Offset 0x1C8 is the I/O base. A write is accepted only when write-data bits 31:18 differ from the stored bits 31:18. An accepted write stores bits 31:18 and bit 0 and clears all other bits.
- R6: A write to 0x1C8 whose bits 31:18 equal the stored ones is dropped completely, bit 0 included, and no remap pulse is produced.
- R7: An accepted I/O base write raises io_remap for exactly one cycle. That cycle is the one after the strobe, the same cycle in which ready rises, and io_base already shows the new value in it.
- R8: A write to 0x220 raises cfg_req_valid with cfg_req_write=1. The request carries the configuration-address register as its address and the write data as its data. The request is held steady until cfg_rsp_valid, and bus_ready rises in the cycle after cfg_rsp_valid.
- R9: A read of 0x220 issues a request with cfg_req_write=0. bus_rdata carries the cfg_rsp_rdata value together with the ready pulse.
- R10: Reads of any other offset return zero. Writes to any other offset change nothing that can be read back.
- R11: Every access other than one to the data port completes with bus_ready high for exactly one cycle, in the cycle after the strobe. Read data is valid in that cycle.
- R12: Strobes presented while bus_sel is low produce no ready and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Local address lies in one of the aliased decode windows |
| bus_addr | input | ADDR_W | Byte offset inside the register span |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access complete, one-cycle pulse |
| cfg_req_valid | output | 1 | Downstream configuration request pending |
| cfg_req_write | output | 1 | 1 for a configuration write, 0 for a read |
| cfg_req_addr | output | 32 | Configuration address of the request |
| cfg_req_wdata | output | 32 | Configuration write data |
| cfg_rsp_valid | input | 1 | Downstream acknowledge, one cycle |
| cfg_rsp_rdata | input | 32 | Configuration read data, valid with cfg_rsp_valid |
| io_base | output | 32 | Current I/O window base register |
| io_remap | output | 1 | One-cycle pulse when the I/O window moves |

## Verification
The most delicate case is the I/O base write that changes only bit 0 or only the cleared low bits. A design that compared the whole word, rather than bits 31:18, would store the new enable bit and pulse io_remap. The bench therefore writes such values and checks the read-back and the pulse. Masking is checked with all-ones patterns on the memory-base and I/O-base registers, where a wrong keep-mask leaves stray bits set. Data-port cycles go through a responder with several cycles of latency. A port that completed early or used the wrong address shows a short wait count or a wrong recorded address. Unmapped offsets and deselected strobes are then read back to catch decoding that leaks writes.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

   localparam int unsigned WORD_W = 32;

   // reset value of one configuration word, stored in little-endian byte order
   function automatic logic [WORD_W-1:0] cfg_reset_word(input int idx,
                                                        input logic [15:0] vendor,
                                                        input logic [15:0] device);
      logic [WORD_W-1:0] w;
      case (idx)
         0:       w = {device, vendor};
         1:       w = 32'h0290_0080;
         default: w = '0;
      endcase
      return w;
   endfunction

   function automatic logic [WORD_W-1:0] byte_swap(input logic [WORD_W-1:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CFG,
      SEL_ADDR,
      SEL_MEM,
      SEL_IO,
      SEL_PORT
   } reg_sel_e;

endpackage

// File: rtl/pcib_cfg_space.sv
module pcib_cfg_space
   import pcib_pkg::*;
#(
   parameter int unsigned CFG_WORDS      = 64,
   parameter logic [15:0] VENDOR_ID      = 16'hFFFF,
   parameter logic [15:0] DEVICE_ID      = 16'hFFFF,
   parameter bit          BUS_BIG_ENDIAN = 1'b0,
   localparam int unsigned IDX_W         = $clog2(CFG_WORDS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);

   if (CFG_WORDS < 2 || (CFG_WORDS & (CFG_WORDS - 1)) != 0) begin : g_bad_words
      $error("CFG_WORDS must be a power of two of at least 2");
   end

   logic [WORD_W-1:0] words [CFG_WORDS];
   logic [WORD_W-1:0] store_val;
   logic [WORD_W-1:0] raw_rd;

   assign raw_rd = words[idx];

   // local storage is always little-endian; a big-endian bus swaps on the way
   if (BUS_BIG_ENDIAN) begin : g_swap
      assign store_val = byte_swap(wdata);
      assign rdata     = byte_swap(raw_rd);
   end else begin : g_direct
      assign store_val = wdata;
      assign rdata     = raw_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CFG_WORDS; i++) begin
            words[i] <= cfg_reset_word(i, VENDOR_ID, DEVICE_ID);
         end
      end else if (wr_en) begin
         words[idx] <= store_val;
      end
   end

endmodule

// File: rtl/pcib_win_regs.sv
module pcib_win_regs
   import pcib_pkg::*;
#(
   parameter int unsigned MEM_LSB   = 24,
   parameter int unsigned IO_LSB    = 18,
   parameter logic [31:0] IO_RESET  = 32'hFE24_0000,
   localparam logic [31:0] MEM_KEEP = {{(32-MEM_LSB){1'b1}}, {(MEM_LSB-1){1'b0}}, 1'b1},
   localparam logic [31:0] IO_KEEP  = {{(32-IO_LSB){1'b1}}, {(IO_LSB-1){1'b0}}, 1'b1}
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic              mem_we,
   input  logic              io_we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] cfg_addr,
   output logic [WORD_W-1:0] mem_base,
   output logic [WORD_W-1:0] io_base,
   output logic              io_remap
);

   if (MEM_LSB < 2 || MEM_LSB > 31) begin : g_bad_mem
      $error("MEM_LSB out of range");
   end
   if (IO_LSB < 2 || IO_LSB > 31) begin : g_bad_io
      $error("IO_LSB out of range");
   end

   logic io_accept;

   // a write that leaves the window where it is does nothing, enable bit included
   assign io_accept = io_we && (wdata[31:IO_LSB] != io_base[31:IO_LSB]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_addr <= '0;
         mem_base <= '0;
         io_base  <= IO_RESET & IO_KEEP;
         io_remap <= 1'b0;
      end else begin
         io_remap <= io_accept;
         if (addr_we) cfg_addr <= wdata;
         if (mem_we)  mem_base <= wdata & MEM_KEEP;
         if (io_accept) io_base <= wdata & IO_KEEP;
      end
   end

   p_remap_moves_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      io_remap |-> (io_base[31:IO_LSB] != $past(io_base[31:IO_LSB])));

   p_base_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !io_remap |-> $stable(io_base));

endmodule

// File: rtl/pcib_data_port.sv
module pcib_data_port
   import pcib_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_write,
   input  logic [WORD_W-1:0] start_addr,
   input  logic [WORD_W-1:0] start_wdata,
   output logic              idle,
   output logic              done,
   output logic [WORD_W-1:0] done_rdata,
   output logic              req_valid,
   output logic              req_write,
   output logic [WORD_W-1:0] req_addr,
   output logic [WORD_W-1:0] req_wdata,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_rdata
);

   logic busy_q;

   assign idle       = !busy_q;
   assign req_valid  = busy_q;
   assign done       = busy_q && rsp_valid;
   assign done_rdata = req_write ? '0 : rsp_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_wdata <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q    <= 1'b1;
            req_write <= start_write;
            req_addr  <= start_addr;
            req_wdata <= start_write ? start_wdata : '0;
         end
      end else if (rsp_valid) begin
         busy_q <= 1'b0;
      end
   end

   p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=>
         (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));

endmodule

// File: rtl/pcib_regif.sv
module pcib_regif
   import pcib_pkg::*;
#(
   parameter int unsigned ADDR_W         = 10,
   parameter int unsigned CFG_WORDS      = 64,
   parameter logic [15:0] VENDOR_ID      = 16'hFFFF,
   parameter logic [15:0] DEVICE_ID      = 16'hFFFF,
   parameter bit          BUS_BIG_ENDIAN = 1'b0,
   parameter int unsigned MEM_LSB        = 24,
   parameter int unsigned IO_LSB         = 18,
   parameter logic [31:0] IO_RESET       = 32'hFE24_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ready,
   output logic              cfg_req_valid,
   output logic              cfg_req_write,
   output logic [31:0]       cfg_req_addr,
   output logic [31:0]       cfg_req_wdata,
   input  logic              cfg_rsp_valid,
   input  logic [31:0]       cfg_rsp_rdata,
   output logic [31:0]       io_base,
   output logic              io_remap
);

   localparam int unsigned IDX_W    = $clog2(CFG_WORDS);
   localparam int unsigned CFG_SPAN = CFG_WORDS * 4;
   localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(12'h1C0);
   localparam logic [ADDR_W-1:0] OFF_MEM  = ADDR_W'(12'h1C4);
   localparam logic [ADDR_W-1:0] OFF_IO   = ADDR_W'(12'h1C8);
   localparam logic [ADDR_W-1:0] OFF_PORT = ADDR_W'(12'h220);

   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must cover the 0x224-byte span");
   end
   if (CFG_SPAN > 32'h1C0) begin : g_bad_span
      $error("configuration space overlaps the control registers");
   end

   reg_sel_e          sel;
   logic              strobe, is_write, is_read;
   logic              reg_strobe, port_start;
   logic [WORD_W-1:0] cfg_rdata, cfg_addr_q, mem_base_q, io_base_q;
   logic [WORD_W-1:0] reg_rd_val;
   logic              port_idle, port_done;
   logic [WORD_W-1:0] port_rdata;
   logic              ready_q;
   logic [WORD_W-1:0] rdata_q;

   // decode on the offset alone, so every alias window reaches the same registers
   always_comb begin
      if (32'(bus_addr) < CFG_SPAN && bus_addr[1:0] == 2'b00) sel = SEL_CFG;
      else if (bus_addr == OFF_ADDR) sel = SEL_ADDR;
      else if (bus_addr == OFF_MEM)  sel = SEL_MEM;
      else if (bus_addr == OFF_IO)   sel = SEL_IO;
      else if (bus_addr == OFF_PORT) sel = SEL_PORT;
      else                           sel = SEL_NONE;
   end

   assign is_write   = bus_wr;
   assign is_read    = bus_rd && !bus_wr;
   assign strobe     = bus_sel && (is_write || is_read) && port_idle;
   assign reg_strobe = strobe && (sel != SEL_PORT);
   assign port_start = strobe && (sel == SEL_PORT);

   pcib_cfg_space #(
      .CFG_WORDS      (CFG_WORDS),
      .VENDOR_ID      (VENDOR_ID),
      .DEVICE_ID      (DEVICE_ID),
      .BUS_BIG_ENDIAN (BUS_BIG_ENDIAN)
   ) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_strobe && is_write && sel == SEL_CFG),
      .idx   (bus_addr[2 +: IDX_W]),
      .wdata (bus_wdata),
      .rdata (cfg_rdata)
   );

   pcib_win_regs #(
      .MEM_LSB  (MEM_LSB),
      .IO_LSB   (IO_LSB),
      .IO_RESET (IO_RESET)
   ) win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_we  (reg_strobe && is_write && sel == SEL_ADDR),
      .mem_we   (reg_strobe && is_write && sel == SEL_MEM),
      .io_we    (reg_strobe && is_write && sel == SEL_IO),
      .wdata    (bus_wdata),
      .cfg_addr (cfg_addr_q),
      .mem_base (mem_base_q),
      .io_base  (io_base_q),
      .io_remap (io_remap)
   );

   pcib_data_port port_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (port_start),
      .start_write (is_write),
      .start_addr  (cfg_addr_q),
      .start_wdata (bus_wdata),
      .idle        (port_idle),
      .done        (port_done),
      .done_rdata  (port_rdata),
      .req_valid   (cfg_req_valid),
      .req_write   (cfg_req_write),
      .req_addr    (cfg_req_addr),
      .req_wdata   (cfg_req_wdata),
      .rsp_valid   (cfg_rsp_valid),
      .rsp_rdata   (cfg_rsp_rdata)
   );

   always_comb begin
      case (sel)
         SEL_CFG:  reg_rd_val = cfg_rdata;
         SEL_ADDR: reg_rd_val = cfg_addr_q;
         SEL_MEM:  reg_rd_val = mem_base_q;
         SEL_IO:   reg_rd_val = io_base_q;
         default:  reg_rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         ready_q <= reg_strobe || port_done;
         if (port_done)                 rdata_q <= port_rdata;
         else if (reg_strobe && is_read) rdata_q <= reg_rd_val;
         else                           rdata_q <= '0;
      end
   end

   assign bus_ready = ready_q;
   assign bus_rdata = rdata_q;
   assign io_base   = io_base_q;

   p_port_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_valid && cfg_rsp_valid) |=> bus_ready);

   p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   p_remap_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      io_remap |-> bus_ready);

endmodule

// File: tb/pcib_regif_tb.sv
`timescale 1ns/1ps
module pcib_regif_tb_top;

   localparam logic [15:0] VEN = 16'hA5C3;
   localparam logic [15:0] DEV = 16'h7E11;
   localparam int LAT = 3;
   localparam int NOREADY = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        cfg_req_valid, cfg_req_write;
   logic [31:0] cfg_req_addr, cfg_req_wdata;
   logic        cfg_rsp_valid;
   logic [31:0] cfg_rsp_rdata;
   logic [31:0] io_base;
   logic        io_remap;

   int checks = 0;
   int fails = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   pcib_regif #(.VENDOR_ID(VEN), .DEVICE_ID(DEV)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .cfg_req_valid(cfg_req_valid), .cfg_req_write(cfg_req_write),
      .cfg_req_addr(cfg_req_addr), .cfg_req_wdata(cfg_req_wdata),
      .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_rdata(cfg_rsp_rdata),
      .io_base(io_base), .io_remap(io_remap)
   );

   // downstream responder: acknowledges after LAT waiting cycles
   int          rsp_cnt;
   logic        rec_write;
   logic [31:0] rec_addr, rec_wdata;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rsp_valid <= 1'b0;
         cfg_rsp_rdata <= '0;
         rsp_cnt       <= 0;
         rec_write     <= 1'b0;
         rec_addr      <= '0;
         rec_wdata     <= '0;
      end else begin
         cfg_rsp_valid <= 1'b0;
         if (cfg_req_valid && !cfg_rsp_valid) begin
            if (rsp_cnt == LAT) begin
               cfg_rsp_valid <= 1'b1;
               cfg_rsp_rdata <= cfg_req_addr ^ 32'h5A5A_5A5A;
               rec_write     <= cfg_req_write;
               rec_addr      <= cfg_req_addr;
               rec_wdata     <= cfg_req_wdata;
               rsp_cnt       <= 0;
            end else begin
               rsp_cnt <= rsp_cnt + 1;
            end
         end
      end
   end

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   logic [31:0] a_rd;
   int          a_wait;
   bit          a_remap, a_remap_next, a_ready_next;

   task automatic access(input bit wr, input logic [9:0] addr, input logic [31:0] data, input bit sel);
      @(negedge clk);
      bus_sel = sel; bus_addr = addr; bus_wr = wr; bus_rd = !wr; bus_wdata = data;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      a_wait = 0;
      while (!bus_ready && a_wait < NOREADY) begin
         @(negedge clk);
         a_wait++;
      end
      a_rd = bus_rdata;
      a_remap = io_remap;
      @(negedge clk);
      a_remap_next = io_remap;
      a_ready_next = bus_ready;
   endtask

   // {write, offset, data, expected read}
   localparam int NV = 18;
   localparam logic [74:0] VEC [NV] = '{
      {1'b0, 10'h000, 32'h0, {DEV, VEN}},
      {1'b0, 10'h004, 32'h0, 32'h0290_0080},
      {1'b0, 10'h008, 32'h0, 32'h0},
      {1'b0, 10'h1C0, 32'h0, 32'h0},
      {1'b0, 10'h1C4, 32'h0, 32'h0},
      {1'b0, 10'h1C8, 32'h0, 32'hFE24_0000},
      {1'b1, 10'h010, 32'hA1B2_C3D4, 32'h0},
      {1'b0, 10'h010, 32'h0, 32'hA1B2_C3D4},
      {1'b1, 10'h0FC, 32'h1234_5678, 32'h0},
      {1'b0, 10'h0FC, 32'h0, 32'h1234_5678},
      {1'b1, 10'h1C0, 32'hDEAD_BEEF, 32'h0},
      {1'b0, 10'h1C0, 32'h0, 32'hDEAD_BEEF},
      {1'b1, 10'h1C4, 32'hFFFF_FFFF, 32'h0},
      {1'b0, 10'h1C4, 32'h0, 32'hFF00_0001},
      {1'b1, 10'h1C4, 32'h1234_5678, 32'h0},
      {1'b0, 10'h1C4, 32'h0, 32'h1200_0000},
      {1'b1, 10'h100, 32'h5555_AAAA, 32'h0},
      {1'b0, 10'h100, 32'h0, 32'h0}
   };

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state at the ports
      check(bus_ready == 1'b0, "R2 ready after reset", 32'(bus_ready), 32'h0);
      check(io_remap == 1'b0, "R2 remap after reset", 32'(io_remap), 32'h0);
      check(io_base == 32'hFE24_0000, "R2 io base after reset", io_base, 32'hFE24_0000);
      check(cfg_req_valid == 1'b0, "R2 request after reset", 32'(cfg_req_valid), 32'h0);

      // vector walk: R1 R2 R3 R4 R10 read-backs, R11 timing
      for (int i = 0; i < NV; i++) begin
         access(VEC[i][74], VEC[i][73:64], VEC[i][63:32], 1'b1);
         check(a_wait == 0 && !a_ready_next, $sformatf("R11 ready timing vector %0d", i),
               32'(a_wait), 32'h0);
         if (!VEC[i][74]) begin
            check(a_rd == VEC[i][31:0], $sformatf("R1/R2/R3/R4/R10 read vector %0d", i),
                  a_rd, VEC[i][31:0]);
         end
      end
      // R10 unmapped offset inside the gap, and the span end
      access(1'b0, 10'h1CC, 32'h0, 1'b1);
      check(a_rd == 32'h0, "R10 unmapped read 0x1CC", a_rd, 32'h0);
      access(1'b0, 10'h0FC, 32'h0, 1'b1);
      check(a_rd == 32'h1234_5678, "R10 write to 0x100 left config intact", a_rd, 32'h1234_5678);

      // R5 R7 accepted I/O base write with masking
      access(1'b1, 10'h1C8, 32'h1234_FFFF, 1'b1);
      check(a_remap == 1'b1, "R7 remap with ready", 32'(a_remap), 32'h1);
      check(a_remap_next == 1'b0, "R7 remap one cycle", 32'(a_remap_next), 32'h0);
      check(io_base == 32'h1234_0001, "R5 io base masked", io_base, 32'h1234_0001);
      access(1'b0, 10'h1C8, 32'h0, 1'b1);
      check(a_rd == 32'h1234_0001, "R5 io base read back", a_rd, 32'h1234_0001);

      // R6 only bit 0 differs -> dropped
      access(1'b1, 10'h1C8, 32'h1234_0000, 1'b1);
      check(a_remap == 1'b0, "R6 no remap bit0 only", 32'(a_remap), 32'h0);
      access(1'b0, 10'h1C8, 32'h0, 1'b1);
      check(a_rd == 32'h1234_0001, "R6 bit0 kept", a_rd, 32'h1234_0001);
      // R6 only cleared low bits differ -> dropped
      access(1'b1, 10'h1C8, 32'h1237_FFFE, 1'b1);
      check(a_remap == 1'b0, "R6 no remap low bits", 32'(a_remap), 32'h0);
      check(io_base == 32'h1234_0001, "R6 io base unchanged", io_base, 32'h1234_0001);
      // R5 R7 move again, lowest window bit
      access(1'b1, 10'h1C8, 32'h0004_0000, 1'b1);
      check(a_remap == 1'b1 && io_base == 32'h0004_0000, "R7 second remap", io_base, 32'h0004_0000);

      // R8 data-port write
      access(1'b1, 10'h1C0, 32'h8000_0010, 1'b1);
      access(1'b1, 10'h220, 32'hCAFE_F00D, 1'b1);
      check(a_wait >= LAT && a_wait < NOREADY, "R8 ready waits for ack", 32'(a_wait), 32'(LAT + 2));
      check(rec_write == 1'b1, "R8 request is write", 32'(rec_write), 32'h1);
      check(rec_addr == 32'h8000_0010, "R8 request address", rec_addr, 32'h8000_0010);
      check(rec_wdata == 32'hCAFE_F00D, "R8 request data", rec_wdata, 32'hCAFE_F00D);
      check(!a_ready_next && !cfg_req_valid, "R8 single completion", 32'(cfg_req_valid), 32'h0);

      // R9 data-port read
      access(1'b1, 10'h1C0, 32'h0001_2344, 1'b1);
      access(1'b0, 10'h220, 32'h0, 1'b1);
      check(rec_write == 1'b0, "R9 request is read", 32'(rec_write), 32'h0);
      check(rec_addr == 32'h0001_2344, "R9 request address", rec_addr, 32'h0001_2344);
      check(a_rd == (32'h0001_2344 ^ 32'h5A5A_5A5A), "R9 read data", a_rd, 32'h0001_2344 ^ 32'h5A5A_5A5A);

      // R12 deselected strobes
      access(1'b1, 10'h1C0, 32'h1111_1111, 1'b0);
      check(a_wait == NOREADY, "R12 no ready when deselected", 32'(a_wait), 32'(NOREADY));
      access(1'b1, 10'h1C8, 32'hFFFC_0001, 1'b0);
      check(io_base == 32'h0004_0000, "R12 io base untouched", io_base, 32'h0004_0000);
      access(1'b0, 10'h1C0, 32'h0, 1'b1);
      check(a_rd == 32'h0001_2344, "R12 address register untouched", a_rd, 32'h0001_2344);

      if (!done_flag) begin
         done_flag = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done_flag) begin
         done_flag = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired, run hung (R8 R9 handshake suspected)");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule